// File: doc/BRIEF.md
# Masked Vector Merge and Logic Pipeline

This block keeps a small file of vector registers and streams their elements through a pipelined logic stage. The stage has a fixed latency and accepts one element pair per clock. An instruction names two source registers, or one register and a scalar that is broadcast to every element, plus a destination register, an operation code, an element count and a 64-bit element mask. Results go back into the destination register one element per clock.

Every stored element carries a parity bit that is generated when the element is written. Each operand read during an instruction checks that parity, and a mismatch raises a flag that stays set until the next instruction is accepted. A load port fills registers while the block is idle, and a combinational readback port returns any element. The load port can also store an element with inverted parity, so the error path can be exercised.

Top module: `vmp_merge_pipe`

## Requirements
- R1: The file holds 8 registers of 64 elements of 64 bits. A load (`ld_en`) writes one element at the edge when the block is idle and is ignored while `busy` is high. `rd_data` returns the element selected by `rd_reg`/`rd_idx`.
- R2: For the merge operation, element i of the result is operand 1 when mask bit (63 - i) is 1 and operand 2 when that bit is 0. Mask bit 63 therefore governs element 0 and mask bit 0 governs element 63.
- R3: The operation codes are 0 merge, 1 AND, 2 inclusive OR, 3 exclusive OR and 4 exclusive NOR, each applied bitwise to the two operands. Codes 5 to 7 copy operand 1.
- R4: When `use_scalar` is 1, `scalar` replaces operand 2 for every element and `src2` is not used.
- R5: With n = min(`vlen`, 64), elements 0 to n-1 of the destination are written and elements n to 63 keep their values. A `vlen` above 64 acts as 64.
- R6: For n > 0, `done` is a one-cycle pulse that goes high n + 4 clocks after the edge that accepts `start`. `busy` is high from the accepting edge until the edge that raises `done`.
- R7: With n = 0, no element is written and `done` pulses one clock after the accepting edge.
- R8: A `start` while `busy` is high is ignored.
- R9: An operand read whose stored parity mismatches sets `perr`. `perr` holds until the next accepted `start` clears it. The scalar operand is never checked. A load with `ld_flip` set stores inverted parity.
- R10: The destination may equal a source register. Each element is read before its new value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load one element (idle only) |
| ld_reg | input | 3 | Load register select |
| ld_idx | input | 6 | Load element index |
| ld_data | input | 64 | Load data |
| ld_flip | input | 1 | Store inverted parity with the load |
| rd_reg | input | 3 | Readback register select |
| rd_idx | input | 6 | Readback element index |
| rd_data | output | 64 | Readback data |
| start | input | 1 | Begin an instruction |
| op | input | 3 | Operation code |
| src1 | input | 3 | Operand 1 register |
| src2 | input | 3 | Operand 2 register |
| use_scalar | input | 1 | Broadcast `scalar` as operand 2 |
| scalar | input | 64 | Scalar operand |
| dst | input | 3 | Destination register |
| vlen | input | 7 | Element count |
| vmask | input | 64 | Element mask, bit 63 for element 0 |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Last result written (one-cycle pulse) |
| perr | output | 1 | Parity mismatch seen in the current instruction |

## Verification
The parity error is the state that is hardest to reach from the ports, because correct writes always store good parity. The stimulus plants a bad element through the inverted-parity load. It then reads that element as operand 1 to raise the flag, reads it in the slot the scalar overrides to show it goes unchecked, and starts a clean instruction to show the flag clears. A start and a load are also placed in the middle of a running instruction. Random instructions with random lengths, masks and register overlaps, including in-place ones, are checked element by element against a bench model.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
   typedef enum logic [2:0] {
      OP_MERGE = 3'd0,
      OP_AND   = 3'd1,
      OP_OR    = 3'd2,
      OP_XOR   = 3'd3,
      OP_XNOR  = 3'd4
   } vop_e;
endpackage

// File: rtl/vmp_regfile.sv
module vmp_regfile #(
   parameter int NREG  = 8,
   parameter int ELEMS = 64,
   parameter int W     = 64,
   localparam int RW   = $clog2(NREG),
   localparam int IW   = $clog2(ELEMS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [RW-1:0] wreg,
   input  logic [IW-1:0] widx,
   input  logic [W-1:0]  wdata,
   input  logic          wflip,
   input  logic [RW-1:0] a_reg,
   input  logic [IW-1:0] a_idx,
   output logic [W-1:0]  a_data,
   output logic          a_bad,
   input  logic [RW-1:0] b_reg,
   input  logic [IW-1:0] b_idx,
   output logic [W-1:0]  b_data,
   output logic          b_bad,
   input  logic [RW-1:0] c_reg,
   input  logic [IW-1:0] c_idx,
   output logic [W-1:0]  c_data
);
   localparam int DEPTH = NREG * ELEMS;

   // each word: parity bit on top of the element
   logic [W:0] mem [DEPTH];
   logic [W:0] wa, wb, wc;

   always_ff @(posedge clk) begin
      if (we) mem[{wreg, widx}] <= {(^wdata) ^ wflip, wdata};
   end

   always_comb begin
      wa     = mem[{a_reg, a_idx}];
      wb     = mem[{b_reg, b_idx}];
      wc     = mem[{c_reg, c_idx}];
      a_data = wa[W-1:0];
      b_data = wb[W-1:0];
      c_data = wc[W-1:0];
      a_bad  = ^wa;
      b_bad  = ^wb;
   end
endmodule

// File: rtl/vmp_lane.sv
module vmp_lane
   import vmp_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         m,
   output logic [W-1:0] y
);
   always_comb begin
      case (vop_e'(op))
         OP_MERGE: y = m ? a : b;
         OP_AND:   y = a & b;
         OP_OR:    y = a | b;
         OP_XOR:   y = a ^ b;
         OP_XNOR:  y = ~(a ^ b);
         default:  y = a;
      endcase
   end
endmodule

// File: rtl/vmp_resdly.sv
module vmp_resdly #(
   parameter int DEPTH = 3,
   parameter int PW    = 72
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [PW-1:0] in_p,
   output logic          out_v,
   output logic [PW-1:0] out_p
);
   logic [DEPTH-1:0] v;
   logic [PW-1:0]    p [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v[0] <= 1'b0;
      else        v[0] <= in_v;
   end
   always_ff @(posedge clk) p[0] <= in_p;

   for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) v[k] <= 1'b0;
         else        v[k] <= v[k-1];
      end
      always_ff @(posedge clk) p[k] <= p[k-1];
   end

   assign out_v = v[DEPTH-1];
   assign out_p = p[DEPTH-1];
endmodule

// File: rtl/vmp_merge_pipe.sv
module vmp_merge_pipe
   import vmp_pkg::*;
#(
   parameter int NREG  = 8,
   parameter int ELEMS = 64,
   parameter int W     = 64,
   parameter int VLW   = 7,
   parameter int LAT   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_en,
   input  logic [$clog2(NREG)-1:0]  ld_reg,
   input  logic [$clog2(ELEMS)-1:0] ld_idx,
   input  logic [W-1:0]             ld_data,
   input  logic                     ld_flip,
   input  logic [$clog2(NREG)-1:0]  rd_reg,
   input  logic [$clog2(ELEMS)-1:0] rd_idx,
   output logic [W-1:0]             rd_data,
   input  logic                     start,
   input  logic [2:0]               op,
   input  logic [$clog2(NREG)-1:0]  src1,
   input  logic [$clog2(NREG)-1:0]  src2,
   input  logic                     use_scalar,
   input  logic [W-1:0]             scalar,
   input  logic [$clog2(NREG)-1:0]  dst,
   input  logic [VLW-1:0]           vlen,
   input  logic [ELEMS-1:0]         vmask,
   output logic                     busy,
   output logic                     done,
   output logic                     perr
);
   localparam int RW = $clog2(NREG);
   localparam int IW = $clog2(ELEMS);
   localparam int PW = 1 + IW + W;   // last flag, index, result

   if (LAT < 2) begin : g_bad_lat
      $error("LAT must be at least 2");
   end
   if ((1 << IW) != ELEMS || (1 << RW) != NREG) begin : g_bad_pow2
      $error("NREG and ELEMS must be powers of two");
   end
   if ((1 << VLW) <= ELEMS) begin : g_bad_vlw
      $error("VLW too narrow to express ELEMS");
   end

   // instruction configuration
   logic [2:0]       op_q;
   logic [RW-1:0]    src1_q, src2_q, dst_q;
   logic             usc_q;
   logic [W-1:0]     sc_q;
   logic [ELEMS-1:0] mask_q;
   logic [IW:0]      n_q;

   // sequencer
   logic          busy_q, done_q, perr_q, zero_q;
   logic          iss_on;
   logic [IW-1:0] iss_cnt;
   logic          accept, iss_last;
   logic [VLW-1:0] vl_clip;
   logic [IW:0]   n_in;

   // read stage
   logic [W-1:0]  ra_data, rb_data;
   logic          ra_bad, rb_bad;
   logic          s1_v, s1_last, s1_m, s1_perr;
   logic [IW-1:0] s1_idx;
   logic [W-1:0]  s1_a, s1_b, s1_y;

   // write stage
   logic          wr_pipe, wr_last;
   logic [IW-1:0] wr_idx;
   logic [W-1:0]  wr_data;
   logic [PW-1:0] wr_pl;

   logic          f_we, f_flip;
   logic [RW-1:0] f_reg;
   logic [IW-1:0] f_idx;
   logic [W-1:0]  f_data;

   assign accept   = start && !busy_q;
   assign vl_clip  = (vlen > VLW'(ELEMS)) ? VLW'(ELEMS) : vlen;
   assign n_in     = (IW+1)'(vl_clip);
   assign iss_last = ({1'b0, iss_cnt} == n_q - 1'b1);

   always_ff @(posedge clk) begin
      if (accept) begin
         op_q   <= op;
         src1_q <= src1;
         src2_q <= src2;
         dst_q  <= dst;
         usc_q  <= use_scalar;
         sc_q   <= scalar;
         mask_q <= vmask;
         n_q    <= n_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         perr_q  <= 1'b0;
         zero_q  <= 1'b0;
         iss_on  <= 1'b0;
         iss_cnt <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            perr_q  <= 1'b0;
            iss_on  <= (n_in != '0);
            zero_q  <= (n_in == '0);
            iss_cnt <= '0;
         end else begin
            if (iss_on) begin
               iss_cnt <= iss_cnt + 1'b1;
               if (iss_last) iss_on <= 1'b0;
            end
            if (zero_q) begin
               zero_q <= 1'b0;
               done_q <= 1'b1;
               busy_q <= 1'b0;
            end
            if (wr_pipe && wr_last) begin
               done_q <= 1'b1;
               busy_q <= 1'b0;
            end
            if (s1_v && s1_perr) perr_q <= 1'b1;
         end
      end
   end

   // operand read and parity check
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_v <= 1'b0;
      else        s1_v <= iss_on;
   end

   always_ff @(posedge clk) begin
      s1_last <= iss_last;
      s1_idx  <= iss_cnt;
      s1_a    <= ra_data;
      s1_b    <= usc_q ? sc_q : rb_data;
      s1_m    <= mask_q[~iss_cnt];   // mask bit ELEMS-1-index
      s1_perr <= ra_bad | (rb_bad & !usc_q);
   end

   vmp_lane #(.W(W)) u_lane (
      .op (op_q),
      .a  (s1_a),
      .b  (s1_b),
      .m  (s1_m),
      .y  (s1_y)
   );

   vmp_resdly #(.DEPTH(LAT-1), .PW(PW)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (s1_v),
      .in_p  ({s1_last, s1_idx, s1_y}),
      .out_v (wr_pipe),
      .out_p (wr_pl)
   );
   assign {wr_last, wr_idx, wr_data} = wr_pl;

   // write port: pipeline results, otherwise idle loads
   always_comb begin
      f_we   = wr_pipe | (ld_en & !busy_q);
      f_reg  = wr_pipe ? dst_q   : ld_reg;
      f_idx  = wr_pipe ? wr_idx  : ld_idx;
      f_data = wr_pipe ? wr_data : ld_data;
      f_flip = wr_pipe ? 1'b0    : ld_flip;
   end

   vmp_regfile #(.NREG(NREG), .ELEMS(ELEMS), .W(W)) u_rf (
      .clk    (clk),
      .we     (f_we),
      .wreg   (f_reg),
      .widx   (f_idx),
      .wdata  (f_data),
      .wflip  (f_flip),
      .a_reg  (src1_q),
      .a_idx  (iss_cnt),
      .a_data (ra_data),
      .a_bad  (ra_bad),
      .b_reg  (src2_q),
      .b_idx  (iss_cnt),
      .b_data (rb_data),
      .b_bad  (rb_bad),
      .c_reg  (rd_reg),
      .c_idx  (rd_idx),
      .c_data (rd_data)
   );

   assign busy = busy_q;
   assign done = done_q;
   assign perr = perr_q;
endmodule

// File: rtl/vmp_merge_pipe_chk.sv
module vmp_merge_pipe_chk #(
   parameter int VLW = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [VLW-1:0] vlen,
   input logic           busy,
   input logic           done,
   input logic           perr,
   input logic           wr_pipe
);
   // R6: done is never seen with busy still high
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6: done lasts exactly one cycle
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: results are written only while an instruction is in flight
   a_r6_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pipe |-> busy);

   // R7: zero length finishes one clock after acceptance
   a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && vlen == '0) |-> ##2 done);

   // R8: busy only rises from an accepted start
   a_r8_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R9: acceptance clears the parity flag
   a_r9_perr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> !perr);
endmodule

bind vmp_merge_pipe vmp_merge_pipe_chk #(.VLW(VLW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .vlen    (vlen),
   .busy    (busy),
   .done    (done),
   .perr    (perr),
   .wr_pipe (wr_pipe)
);

// File: tb/tb_vmp_merge_pipe.sv
`timescale 1ns/1ps
module tb_vmp_merge_pipe;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0, ld_flip = 1'b0;
   logic [2:0]  ld_reg = '0, rd_reg = '0;
   logic [5:0]  ld_idx = '0, rd_idx = '0;
   logic [63:0] ld_data = '0, rd_data;
   logic        start = 1'b0, use_scalar = 1'b0;
   logic [2:0]  op = '0, src1 = '0, src2 = '0, dst = '0;
   logic [63:0] scalar = '0, vmask = '0;
   logic [6:0]  vlen = '0;
   logic        busy, done, perr;

   int n_chk = 0, n_fail = 0;
   logic [63:0] mdl [8][64];

   always #2.5 clk = ~clk;

   vmp_merge_pipe dut (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data), .ld_flip(ld_flip),
      .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
      .start(start), .op(op), .src1(src1), .src2(src2), .use_scalar(use_scalar),
      .scalar(scalar), .dst(dst), .vlen(vlen), .vmask(vmask),
      .busy(busy), .done(done), .perr(perr)
   );

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] f_exp(int o, logic [63:0] a, logic [63:0] b, logic m);
      case (o)
         0: return m ? a : b;
         1: return a & b;
         2: return a | b;
         3: return a ^ b;
         4: return ~(a ^ b);
         default: return a;
      endcase
   endfunction

   task automatic do_load(int r, int i, logic [63:0] d, bit flip);
      @(negedge clk);
      ld_en = 1'b1; ld_reg = 3'(r); ld_idx = 6'(i); ld_data = d; ld_flip = flip;
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0; ld_flip = 1'b0;
      mdl[r][i] = d;
   endtask

   task automatic check_reg(int r, string req);
      int bad = 0;
      logic [63:0] fa = '0, fe = '0;
      for (int i = 0; i < 64; i++) begin
         rd_reg = 3'(r); rd_idx = 6'(i);
         #0.1;
         if (rd_data !== mdl[r][i]) begin
            if (bad == 0) begin fa = rd_data; fe = mdl[r][i]; end
            bad++;
         end
      end
      chk(bad == 0, req, $sformatf("reg %0d contents (%0d bad elems)", r, bad), fa, fe);
   endtask

   task automatic set_cfg(int o, int s1, int s2, bit us, logic [63:0] sc, int d, int vl,
                          logic [63:0] m);
      op = 3'(o); src1 = 3'(s1); src2 = 3'(s2); use_scalar = us; scalar = sc;
      dst = 3'(d); vlen = 7'(vl); vmask = m;
   endtask

   task automatic model_exec(int o, int s1, int s2, bit us, logic [63:0] sc, int d, int vl,
                             logic [63:0] m);
      logic [63:0] a [64];
      logic [63:0] b [64];
      int n = (vl > 64) ? 64 : vl;
      for (int i = 0; i < 64; i++) begin a[i] = mdl[s1][i]; b[i] = mdl[s2][i]; end
      for (int i = 0; i < n; i++)
         mdl[d][i] = f_exp(o, a[i], us ? sc : b[i], m[63-i]);
   endtask

   task automatic wait_done(inout int cyc);
      while (!done && cyc < 400) begin
         @(posedge clk); @(negedge clk); cyc++;
      end
   endtask

   task automatic run(int o, int s1, int s2, bit us, logic [63:0] sc, int d, int vl,
                      logic [63:0] m, string req);
      int cyc = 0;
      int n = (vl > 64) ? 64 : vl;
      int exp_lat = (n == 0) ? 1 : n + 4;
      @(negedge clk);
      set_cfg(o, s1, s2, us, sc, d, vl, m);
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      chk(cyc == exp_lat, "R6", $sformatf("done latency for n=%0d (%s)", n, req), 64'(cyc), 64'(exp_lat));
      model_exec(o, s1, s2, us, sc, d, vl, m);
      check_reg(d, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd7151));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && perr == 1'b0, "R6", "reset outputs",
          {61'd0, busy, done, perr}, 64'd0);
      rst_n = 1'b1;

      // R1: fill the file
      for (int r = 0; r < 8; r++)
         for (int i = 0; i < 64; i++)
            do_load(r, i, {$urandom, $urandom}, 1'b0);
      check_reg(3, "R1");

      // R2: mask order, bit 63 -> element 0, bit 0 -> element 63
      run(0, 0, 1, 1'b0, '0, 2, 64, 64'h8000_0000_0000_0001, "R2");
      run(0, 3, 4, 1'b0, '0, 5, 64, 64'hF0F0_1234_8765_0F0F, "R2");
      // R3: logic operations and unused codes
      run(1, 0, 1, 1'b0, '0, 6, 64, '0, "R3");
      run(2, 2, 3, 1'b0, '0, 6, 64, '0, "R3");
      run(3, 4, 5, 1'b0, '0, 7, 64, '0, "R3");
      run(4, 1, 7, 1'b0, '0, 2, 64, '0, "R3");
      run(6, 3, 0, 1'b0, '0, 4, 64, '0, "R3");
      // R4: scalar broadcast
      run(0, 1, 6, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 3, 64, 64'h0123_4567_89AB_CDEF, "R4");
      run(3, 2, 6, 1'b1, 64'hFFFF_0000_FFFF_0000, 4, 64, '0, "R4");
      // R5: partial and oversize lengths
      run(2, 0, 1, 1'b0, '0, 7, 5, '0, "R5");
      run(4, 5, 6, 1'b0, '0, 0, 100, '0, "R5");
      run(0, 2, 3, 1'b0, '0, 1, 63, 64'hAAAA_5555_AAAA_5555, "R5");
      // R7: zero length
      run(1, 0, 1, 1'b0, '0, 5, 0, '0, "R7");
      // R10: in place
      run(3, 6, 6, 1'b0, '0, 6, 64, '0, "R10");
      run(0, 4, 2, 1'b0, '0, 2, 40, 64'hC3C3_3C3C_9999_6666, "R10");

      // R8/R1: start and load while busy are ignored
      begin
         int cyc = 0;
         logic [63:0] keep7 = mdl[7][0];
         @(negedge clk);
         set_cfg(2, 0, 1, 1'b0, '0, 3, 30, '0);
         start = 1'b1;
         @(posedge clk); @(negedge clk);
         start = 1'b0;
         @(posedge clk); @(negedge clk); cyc = 1;
         set_cfg(1, 4, 5, 1'b0, '0, 5, 64, '0);
         start = 1'b1;
         ld_en = 1'b1; ld_reg = 3'd7; ld_idx = 6'd0; ld_data = ~keep7;
         @(posedge clk); @(negedge clk); cyc = 2;
         start = 1'b0; ld_en = 1'b0;
         wait_done(cyc);
         chk(cyc == 34, "R8", "latency of first instruction", 64'(cyc), 64'd34);
         model_exec(2, 0, 1, 1'b0, '0, 3, 30, '0);
         check_reg(3, "R8");
         check_reg(5, "R8");
         check_reg(7, "R1");
         repeat (10) @(negedge clk);
         chk(busy == 1'b0, "R8", "no second instruction ran", 64'(busy), 64'd0);
      end

      // R9: parity
      do_load(5, 3, 64'h0F0F_0000_1111_2222, 1'b1);
      run(2, 5, 1, 1'b0, '0, 6, 10, '0, "R9");
      chk(perr == 1'b1, "R9", "bad operand flagged", 64'(perr), 64'd1);
      repeat (3) @(negedge clk);
      chk(perr == 1'b1, "R9", "flag held while idle", 64'(perr), 64'd1);
      run(0, 1, 5, 1'b1, 64'h5, 2, 10, '0, "R9");
      chk(perr == 1'b0, "R9", "scalar slot unchecked, flag cleared", 64'(perr), 64'd0);
      run(2, 5, 1, 1'b0, '0, 6, 3, '0, "R9");
      chk(perr == 1'b0, "R9", "bad element beyond length unread", 64'(perr), 64'd0);
      do_load(5, 3, 64'h1, 1'b0);

      // random mix
      for (int t = 0; t < 40; t++) begin
         int o  = int'($urandom_range(0, 7));
         int vl = int'($urandom_range(0, 90));
         run(o, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 1'($urandom),
             {$urandom, $urandom}, int'($urandom_range(0, 7)), vl, {$urandom, $urandom},
             "R5");
         chk(perr == 1'b0, "R9", "no flag on clean data", 64'(perr), 64'd0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule